// File: doc/BRIEF.md
# Bus switch connection and fault monitor

This block is the control logic for a two-channel switch that joins an upstream two-wire bus (data and clock lines) to downstream channels. A host writes a small register file through a plain write port. A write to the connect register names the channels that should be joined. A channel is joined only if both its data and clock lines read high in the cycle the write is taken. A configuration bit can lift that requirement. A refused request lowers a link-ok status bit and pulls the active-low alert output.

The block also watches the two shared internal nodes. For each node it takes two comparator inputs: one that reads below a low threshold and one that reads above a high threshold. A timer counts prescaled ticks while either node reads low. It clears only when both nodes read high, and between the thresholds it holds its value. When the timer reaches the interval picked by a 2-bit mode field, the block opens every channel, sets a sticky stuck flag and pulls alert low. Fault bits stay set until the host clears them with a write.

Top module: `bus_switch_ctrl`

## Requirements
- R1: A channel closes (`ch_en` bit high) on a connect write only if both its `ch_sda` and `ch_scl` bits read 1 in the write cycle. The result appears on the clock edge that takes the write.
- R2: A connect write that requests a channel while either of its lines reads 0 leaves that channel's `ch_en` bit unchanged. It drives `link_ok` to 0 and `alert_n` to 0 from the next edge.
- R3: With override bit 2 of the config register (address 2) set, every requested channel closes whatever its line state, and `link_ok` stays 1.
- R4: In the connect register (address 1), data bit i stands for channel i. A single write may request neither, either or both channels, and a 0 in bit i opens channel i.
- R5: Config bits 1:0 pick the stuck timeout: 00 turns the timer off, while 01, 10 and 11 give 1024, 2048 and 4096 ticks of PRESCALE clocks each. The timer counts while either `node_lo` bit is 1.
- R6: The timer is cleared only when both `node_hi` bits are 1 and no `node_lo` bit is 1. With neither condition it holds its count.
- R7: When the timeout is reached, all `ch_en` bits go to 0 and `stuck_flag` goes to 1 on the next edge, and `alert_n` goes to 0.
- R8: A write to the status register (address 0) restores `link_ok` to 1 when data bit 1 is set, and clears `stuck_flag` when data bit 0 is set. A clear has no lasting effect while the fault condition is still present. `alert_n` is 0 exactly when `link_ok` is 0 or `stuck_flag` is 1.
- R9: After reset all `ch_en` bits are 0, `link_ok` is 1, `stuck_flag` is 0 and `alert_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 status clear, 1 connect, 2 config |
| wr_data | input | 8 | Write data |
| ch_sda | input | 2 | Data line level per downstream channel |
| ch_scl | input | 2 | Clock line level per downstream channel |
| node_lo | input | 2 | Internal node below low threshold (bit 0 data node, bit 1 clock node) |
| node_hi | input | 2 | Internal node above high threshold |
| ch_en | output | 2 | Channel switch closed |
| link_ok | output | 1 | 0 after a refused connection |
| stuck_flag | output | 1 | Sticky stuck-low timeout flag |
| alert_n | output | 1 | Active-low alert |

## Verification
On every cycle, the assertions check the following:
- a channel only closes after a write that saw high lines or the override;
- a refused request lowers `link_ok`;
- the timer holds between the thresholds, clears when both nodes are high, stays at zero in mode 00 and never passes its ceiling;
- a timeout opens every channel.

Only the bench scenarios can show that the timeout lands at the right tick count for each mode, that a partial count survives a stay between the thresholds, and that a clear write is undone while a node is still held low.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
   typedef enum logic [1:0] {
      REG_STATUS  = 2'd0,
      REG_CONNECT = 2'd1,
      REG_CONFIG  = 2'd2
   } bsw_reg_e;

   localparam int CFG_OVR_BIT    = 2;
   localparam int STAT_LINK_BIT  = 1;
   localparam int STAT_STUCK_BIT = 0;
   localparam int TMO_STEPS      = 4;
endpackage

// File: rtl/bsw_conn_gate.sv
module bsw_conn_gate #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic [NUM_CH-1:0] req_bits,
   input  logic [NUM_CH-1:0] sda,
   input  logic [NUM_CH-1:0] scl,
   input  logic              override,
   input  logic              force_off,
   output logic [NUM_CH-1:0] ch_en,
   output logic              fail_evt
);
   logic [NUM_CH-1:0] refuse;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic idle_hi;
      assign idle_hi   = sda[i] & scl[i];
      assign refuse[i] = req_wr & req_bits[i] & ~idle_hi & ~override;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ch_en[i] <= 1'b0;
         end else if (force_off) begin
            ch_en[i] <= 1'b0;
         end else if (req_wr) begin
            if (!req_bits[i])
               ch_en[i] <= 1'b0;
            else if (idle_hi || override)
               ch_en[i] <= 1'b1;
         end
      end

      assert_conn_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(ch_en[i]) && ch_en[i]) |-> $past(req_wr && (override || (sda[i] && scl[i]))));
      assert_refuse_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (refuse[i] && !force_off) |=> ch_en[i] == $past(ch_en[i]));
   end

   assign fail_evt = |refuse;

   assert_ovr_no_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      override |-> !fail_evt);
endmodule

// File: rtl/bsw_stuck_timer.sv
module bsw_stuck_timer #(
   parameter int PRESCALE = 4,
   parameter int TMO_BASE = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       any_lo,
   input  logic       all_hi,
   output logic       hit
);
   localparam int TMAX = TMO_BASE * bsw_pkg::TMO_STEPS;
   localparam int TW   = $clog2(TMAX + 1);

   logic [TW-1:0] timer;
   logic [TW-1:0] limit;
   logic          enabled;
   logic          counting;
   logic          clear_cond;
   logic          tick;

   always_comb begin
      case (mode)
         2'd1:    limit = TW'(TMO_BASE);
         2'd2:    limit = TW'(TMO_BASE * 2);
         default: limit = TW'(TMAX);
      endcase
   end

   assign enabled    = (mode != 2'd0);
   assign clear_cond = !enabled || (!any_lo && all_hi);
   assign counting   = enabled && any_lo && (timer < limit);

   if (PRESCALE == 1) begin : g_nopre
      assign tick = counting;
   end else begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pre <= '0;
         else if (clear_cond)
            pre <= '0;
         else if (counting)
            pre <= (pre == PW'(PRESCALE - 1)) ? '0 : pre + 1'b1;
      end
      assign tick = counting && (pre == PW'(PRESCALE - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         timer <= '0;
      else if (clear_cond)
         timer <= '0;
      else if (tick)
         timer <= timer + 1'b1;
   end

   assign hit = enabled && (timer >= limit);

   assert_mid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && !any_lo && !all_hi) |=> $stable(timer));
   assert_hi_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_lo && all_hi) |=> timer == '0);
   assert_mode_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |=> timer == '0);
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      timer <= TW'(TMAX));
endmodule

// File: rtl/bsw_status.sv
module bsw_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_wr,
   input  logic [1:0] clr_bits,
   input  logic       fail_evt,
   input  logic       hit,
   output logic       link_ok,
   output logic       stuck_flag,
   output logic       alert_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_ok    <= 1'b1;
         stuck_flag <= 1'b0;
      end else begin
         if (fail_evt)
            link_ok <= 1'b0;
         else if (clr_wr && clr_bits[bsw_pkg::STAT_LINK_BIT])
            link_ok <= 1'b1;

         if (hit)
            stuck_flag <= 1'b1;
         else if (clr_wr && clr_bits[bsw_pkg::STAT_STUCK_BIT])
            stuck_flag <= 1'b0;
      end
   end

   assign alert_n = link_ok && !stuck_flag;

   assert_fail_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fail_evt |=> !link_ok);
   assert_stuck_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> stuck_flag);
   assert_link_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_ok && !clr_wr) |=> !link_ok);
endmodule

// File: rtl/bus_switch_ctrl.sv
module bus_switch_ctrl #(
   parameter int NUM_CH   = 2,
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 8,
   parameter int PRESCALE = 4,
   parameter int TMO_BASE = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NUM_CH-1:0] ch_sda,
   input  logic [NUM_CH-1:0] ch_scl,
   input  logic [1:0]        node_lo,
   input  logic [1:0]        node_hi,
   output logic [NUM_CH-1:0] ch_en,
   output logic              link_ok,
   output logic              stuck_flag,
   output logic              alert_n
);
   import bsw_pkg::*;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_chk_ch
      $error("NUM_CH must lie in 1..DATA_W");
   end
   if (DATA_W <= CFG_OVR_BIT) begin : g_chk_dw
      $error("DATA_W too narrow for config fields");
   end
   if (ADDR_W < 2) begin : g_chk_aw
      $error("ADDR_W must be at least 2");
   end
   if (PRESCALE < 1 || TMO_BASE < 1) begin : g_chk_tmo
      $error("PRESCALE and TMO_BASE must be positive");
   end

   logic       wr_status, wr_connect, wr_config;
   logic [1:0] cfg_mode;
   logic       cfg_ovr;
   logic       any_lo, all_hi;
   logic       hit, fail_evt;

   assign wr_status  = wr_en && (wr_addr == ADDR_W'(REG_STATUS));
   assign wr_connect = wr_en && (wr_addr == ADDR_W'(REG_CONNECT));
   assign wr_config  = wr_en && (wr_addr == ADDR_W'(REG_CONFIG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_mode <= 2'd0;
         cfg_ovr  <= 1'b0;
      end else if (wr_config) begin
         cfg_mode <= wr_data[1:0];
         cfg_ovr  <= wr_data[CFG_OVR_BIT];
      end
   end

   assign any_lo = |node_lo;
   assign all_hi = &node_hi;

   bsw_conn_gate #(.NUM_CH(NUM_CH)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_wr   (wr_connect),
      .req_bits (wr_data[NUM_CH-1:0]),
      .sda      (ch_sda),
      .scl      (ch_scl),
      .override (cfg_ovr),
      .force_off(hit),
      .ch_en    (ch_en),
      .fail_evt (fail_evt)
   );

   bsw_stuck_timer #(.PRESCALE(PRESCALE), .TMO_BASE(TMO_BASE)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (cfg_mode),
      .any_lo(any_lo),
      .all_hi(all_hi),
      .hit   (hit)
   );

   bsw_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_wr    (wr_status),
      .clr_bits  (wr_data[1:0]),
      .fail_evt  (fail_evt),
      .hit       (hit),
      .link_ok   (link_ok),
      .stuck_flag(stuck_flag),
      .alert_n   (alert_n)
   );

   assert_timeout_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (ch_en == '0) && !alert_n);
   assert_alert_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_n |-> (!link_ok || stuck_flag));
endmodule

// File: tb/tb_bus_switch_ctrl.sv
module tb_bus_switch_ctrl;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] ch_sda = 2'b11, ch_scl = 2'b11;
   logic [1:0] node_lo = 2'b00, node_hi = 2'b11;
   logic [1:0] ch_en;
   logic       link_ok, stuck_flag, alert_n;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bus_switch_ctrl #(.PRESCALE(P), .TMO_BASE(1024)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ch_sda(ch_sda), .ch_scl(ch_scl), .node_lo(node_lo), .node_hi(node_hi),
      .ch_en(ch_en), .link_ok(link_ok), .stuck_flag(stuck_flag), .alert_n(alert_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic lines_idle();
      @(negedge clk);
      node_lo = 2'b00; node_hi = 2'b11;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R9 ch_en", ch_en, 0);
      chk("R9 link_ok", link_ok, 1);
      chk("R9 stuck_flag", stuck_flag, 0);
      chk("R9 alert_n", alert_n, 1);
   endtask

   task automatic t_connect();
      ch_sda = 2'b11; ch_scl = 2'b11;
      do_write(2'd1, 8'h01);
      chk("R1 ch0 closes on idle lines", ch_en, 1);
      do_write(2'd1, 8'h03);
      chk("R4 both channels", ch_en, 3);
      do_write(2'd1, 8'h02);
      chk("R4 ch0 opened by zero bit", ch_en, 2);
      do_write(2'd1, 8'h00);
      chk("R4 neither channel", ch_en, 0);
      chk("R1 no alert on good connect", alert_n, 1);
   endtask

   task automatic t_refuse();
      ch_sda = 2'b01; ch_scl = 2'b11;
      do_write(2'd1, 8'h03);
      chk("R2 ch1 refused ch0 closed", ch_en, 1);
      chk("R2 link_ok low", link_ok, 0);
      chk("R2 alert_n low", alert_n, 0);
      ch_sda = 2'b11; ch_scl = 2'b10;
      do_write(2'd1, 8'h01);
      chk("R2 low scl keeps state", ch_en, 1);
      do_write(2'd0, 8'h02);
      chk("R8 link_ok restored", link_ok, 1);
      chk("R8 alert released", alert_n, 1);
      do_write(2'd1, 8'h00);
      ch_sda = 2'b11; ch_scl = 2'b11;
   endtask

   task automatic t_override();
      do_write(2'd2, 8'h04);
      ch_sda = 2'b00; ch_scl = 2'b00;
      do_write(2'd1, 8'h03);
      chk("R3 override closes both", ch_en, 3);
      chk("R3 no fault under override", link_ok, 1);
      do_write(2'd1, 8'h00);
      do_write(2'd2, 8'h00);
      ch_sda = 2'b11; ch_scl = 2'b11;
   endtask

   task automatic t_timeout(input logic [1:0] mode, input int ticks);
      do_write(2'd2, {6'd0, mode});
      do_write(2'd1, 8'h03);
      chk("R7 precondition connected", ch_en, 3);
      @(negedge clk);
      node_lo = 2'b01; node_hi = 2'b00;
      repeat (ticks * P - 3) @(negedge clk);
      chk("R5 no timeout before limit", stuck_flag, 0);
      repeat (6) @(negedge clk);
      chk("R5 timeout at limit", stuck_flag, 1);
      chk("R7 channels opened", ch_en, 0);
      chk("R7 alert low", alert_n, 0);
      do_write(2'd0, 8'h01);
      @(negedge clk);
      chk("R8 clear undone while low", stuck_flag, 1);
      lines_idle();
      do_write(2'd0, 8'h01);
      chk("R8 stuck cleared", stuck_flag, 0);
      chk("R8 alert released", alert_n, 1);
   endtask

   task automatic t_hyst();
      do_write(2'd2, 8'h01);
      @(negedge clk);
      node_lo = 2'b10; node_hi = 2'b00;
      repeat (600 * P) @(negedge clk);
      node_lo = 2'b00; node_hi = 2'b01;
      repeat (3000) @(negedge clk);
      chk("R6 mid band no timeout", stuck_flag, 0);
      node_lo = 2'b10; node_hi = 2'b00;
      repeat (424 * P - 3) @(negedge clk);
      chk("R6 count kept before limit", stuck_flag, 0);
      repeat (6) @(negedge clk);
      chk("R6 count kept across mid band", stuck_flag, 1);
      lines_idle();
      do_write(2'd0, 8'h01);
      node_lo = 2'b01; node_hi = 2'b00;
      repeat (600 * P) @(negedge clk);
      node_lo = 2'b00; node_hi = 2'b11;
      repeat (3) @(negedge clk);
      node_lo = 2'b01; node_hi = 2'b00;
      repeat (430 * P) @(negedge clk);
      chk("R6 cleared by both high", stuck_flag, 0);
      repeat (600 * P) @(negedge clk);
      chk("R6 fresh count reaches limit", stuck_flag, 1);
      lines_idle();
      do_write(2'd0, 8'h01);
   endtask

   task automatic t_mode_off();
      do_write(2'd2, 8'h00);
      @(negedge clk);
      node_lo = 2'b11; node_hi = 2'b00;
      repeat (20000) @(negedge clk);
      chk("R5 mode 00 disables timer", stuck_flag, 0);
      lines_idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_connect();
      t_refuse();
      t_override();
      t_timeout(2'd1, 1024);
      t_timeout(2'd2, 2048);
      t_timeout(2'd3, 4096);
      t_hyst();
      t_mode_off();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule